// File: doc/BRIEF.md
# Bit-Serial Word Receiver

This block assembles a 16-bit word from a serial network line, one bit at a time. The line presents each bit together with a strobe. Software first arms the receiver with an enable pulse. The receiver then waits for a strobe, shifts the data bit in, and waits for the strobe to drop before it takes the next bit. After the sixteenth bit it raises a wakeup so that the processor collects the word.

A pad indication fills out a partial word without further strobes. Each missing bit is shifted in from the data line, one every two cycles. A word completed this way is flagged as the last word of a message. That word uses a longer wakeup sequence with three phases. It waits for a first read, then for that read to be released, then for a second read, and only after the second read does it return to idle. A read strobe during reception abandons the word in progress.

The controller holds its state in a 3-bit register with the codes idle=0, wait-for-bit=1, clock=2, last-wakeup=3, handshake=5, last-delay=6 and wakeup=7. The unused code 4 falls back to idle.

Top module: `ser_rx_top`

## Requirements
- R1: After reset, `word_out` is zero and both `wakeup` and `last_word` are low.
- R2: In idle, strobes are ignored until `in_en` arms the receiver. While `in_en` stays high after arming, strobes shift nothing. A word received after such stimulus needs a full 16 new bits before `wakeup` rises.
- R3: Each strobe period shifts `data_bit` once into bit 0 of `word_out`, and earlier bits move up one place, so the first bit received ends in bit 15. Holding the strobe high for extra cycles causes no extra shift.
- R4: When the strobe drops after the sixteenth bit with `pad` low, `wakeup` goes high and `last_word` stays low. `word_out` then holds the 16 received bits.
- R5: In the plain wakeup state, a read strobe returns the block to idle, and `wakeup` goes low on the next cycle.
- R6: If `pad` is high when the strobe drops on a partial word, the block shifts in `data_bit` without strobes until 16 bits are held. It then raises both `wakeup` and `last_word`. A sixteenth bit that ends with `pad` high does the same.
- R7: After a last-word wakeup, a read drives `wakeup` low with `last_word` still high, for as long as the read is held. Releasing the read gives `wakeup` high and `last_word` low. A second read returns the block to idle with both outputs low.
- R8: A read strobe during reception abandons the word and the bit count, so the next armed word needs all 16 bits.
- R9: `wakeup` stays low while fewer than 16 bits of the current word have been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | Processor read strobe |
| in_en | input | 1 | Input enable, arms the receiver |
| pad | input | 1 | Fill the rest of the word and mark it as last |
| bit_stb | input | 1 | Per-bit line strobe |
| data_bit | input | 1 | Serial data bit |
| word_out | output | 16 | Assembled word |
| last_word | output | 1 | Last-word flag |
| wakeup | output | 1 | Word-ready request to the processor |

## Verification
The hardest case to reach is the release phase of the last-word wakeup. The only path to it goes through a padded word completion, a held read and its release. Along that path `wakeup` falls and then rises again, so a plain edge monitor would mistake the second rise for a new word. The bench therefore drives padded words to completion and steps the read strobe through hold and release, checking both outputs at every phase. The monitor pops an expected word only on a rise of `wakeup` that `last_word` did not precede. A second hidden case is a bit count left over after an abandoned or wrongly armed word. The bench exposes it by checking that `wakeup` stays low after exactly 15 fresh bits.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;
    localparam int WORD_W = 16;
    localparam int CNT_W  = $clog2(WORD_W);

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WAIT    = 3'd1,
        ST_CLK     = 3'd2,
        ST_LASTWK  = 3'd3,
        ST_HSK     = 3'd5,
        ST_LASTDLY = 3'd6,
        ST_WAKE    = 3'd7
    } rx_state_t;

    typedef struct packed {
        logic rd;
        logic en;
        logic pad;
        logic stb;
        logic full;
    } rx_ctl_t;

    function automatic logic is_last_state(rx_state_t s);
        return (s == ST_LASTWK) || (s == ST_LASTDLY);
    endfunction

    function automatic logic is_wake_state(rx_state_t s);
        return (s == ST_WAKE) || (s == ST_LASTWK);
    endfunction
endpackage

// File: rtl/ser_rx_next.sv
module ser_rx_next
    import ser_rx_pkg::*;
(
    input  rx_state_t cur,
    input  rx_ctl_t   ctl,
    output rx_state_t nxt
);
    always_comb begin
        nxt = cur;
        unique case (cur)
            ST_IDLE: begin
                if (ctl.en) nxt = ST_WAIT;
                if (ctl.rd) nxt = ST_IDLE;
            end
            ST_WAIT: begin
                if (ctl.stb && !ctl.en) nxt = ST_CLK;
                if (ctl.rd) nxt = ST_IDLE;
            end
            ST_CLK: begin
                nxt = ST_HSK;
                if (ctl.rd) nxt = ST_IDLE;
            end
            ST_HSK: begin
                if (!ctl.stb) begin
                    if (ctl.full) nxt = ctl.pad ? ST_LASTWK : ST_WAKE;
                    else          nxt = ctl.pad ? ST_CLK : ST_WAIT;
                end
                if (ctl.rd) nxt = ST_IDLE;
            end
            ST_LASTWK:  nxt = ctl.rd ? ST_LASTDLY : ST_LASTWK;
            ST_LASTDLY: nxt = ctl.rd ? ST_LASTDLY : ST_WAKE;
            ST_WAKE:    nxt = ctl.rd ? ST_IDLE : ST_WAKE;
            default:    nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/ser_rx_shift.sv
module ser_rx_shift
    import ser_rx_pkg::*;
#(
    parameter int W  = WORD_W,
    localparam int CW = $clog2(W)
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         clear,
    input  logic         din,
    output logic [W-1:0] word,
    output logic         full
);
    localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
            cnt  <= '0;
            full <= 1'b0;
        end else if (clear) begin
            cnt  <= '0;
            full <= 1'b0;
        end else if (shift_en) begin
            word <= {word[W-2:0], din};
            cnt  <= cnt + 1'b1;
            full <= (cnt == LAST_IDX);
        end
    end

    AST_WORD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(word)); // R3
    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt == '0) && !full); // R8
endmodule

// File: rtl/ser_rx_top.sv
module ser_rx_top
    import ser_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_stb,
    input  logic              in_en,
    input  logic              pad,
    input  logic              bit_stb,
    input  logic              data_bit,
    output logic [WORD_W-1:0] word_out,
    output logic              last_word,
    output logic              wakeup
);
    rx_state_t st, st_nxt;
    rx_ctl_t   ctl;
    logic      full;

    assign ctl = '{rd: rd_stb, en: in_en, pad: pad, stb: bit_stb, full: full};

    ser_rx_next u_next (
        .cur (st),
        .ctl (ctl),
        .nxt (st_nxt)
    );

    ser_rx_shift #(.W(WORD_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (st == ST_CLK),
        .clear    (st == ST_IDLE),
        .din      (data_bit),
        .word     (word_out),
        .full     (full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            last_word <= 1'b0;
        end else begin
            st        <= st_nxt;
            last_word <= is_last_state(st_nxt);
        end
    end

    assign wakeup = is_wake_state(st);

    AST_CLK_TO_HSK: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CLK && !rd_stb) |=> (st == ST_HSK)); // R3
    AST_WAKE_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(wakeup) |-> ($past(st) == ST_HSK || $past(st) == ST_LASTDLY)); // R4
    AST_LAST_FLAG: assert property (@(posedge clk) disable iff (rst)
        last_word |-> (st == ST_LASTWK || st == ST_LASTDLY)); // R7
    AST_READ_ABORT: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && (st == ST_WAIT || st == ST_CLK || st == ST_HSK)) |=> (st == ST_IDLE)); // R8
    AST_NO_IDLE_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |=> $stable(word_out)); // R2
endmodule

// File: tb/ser_rx_top_test.sv
module ser_rx_top_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd_stb = 0, in_en = 0, pad = 0, bit_stb = 0, data_bit = 0;
    logic [15:0] word_out;
    logic last_word, wakeup;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    typedef struct packed { logic [15:0] w; logic last; } exp_t;
    exp_t sb_q[$];
    logic wk_prev = 0, lw_prev = 0;

    always #4 clk = ~clk;

    ser_rx_top uut (
        .clk(clk), .rst(rst), .rd_stb(rd_stb), .in_en(in_en), .pad(pad),
        .bit_stb(bit_stb), .data_bit(data_bit),
        .word_out(word_out), .last_word(last_word), .wakeup(wakeup)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("[TB] FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops an expected word on each fresh wakeup rise
    always @(negedge clk) begin
        if (!rst) begin
            if (wakeup && !wk_prev && !lw_prev) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R4 unexpected wakeup", {15'd0, last_word, word_out}, 32'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(word_out == e.w, "R3/R4/R6 word", {16'd0, word_out}, {16'd0, e.w});
                    check(last_word == e.last, "R4/R6 last_word", {31'd0, last_word}, {31'd0, e.last});
                end
            end
            wk_prev = wakeup;
            lw_prev = last_word;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            n_tests++;
            $display("[TB] FAIL watchdog actual=%0d expected<150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic arm();
        in_en = 1; @(negedge clk); in_en = 0;
    endtask

    task automatic send_bit(input logic b, input int hold, input logic p, input logic padv);
        data_bit = b; bit_stb = 1;
        @(negedge clk); @(negedge clk);
        repeat (hold) @(negedge clk);
        pad = p; data_bit = padv; bit_stb = 0;
        @(negedge clk);
    endtask

    task automatic wait_wake();
        for (int i = 0; i < 100 && !wakeup; i++) @(negedge clk);
    endtask

    task automatic rd_pulse();
        rd_stb = 1; @(negedge clk); rd_stb = 0; @(negedge clk);
    endtask

    // driver: sends nbits of pattern MSB first, pads the rest if padded
    task automatic send_word(input logic [15:0] pat, input int nbits, input logic padded,
                             input logic padv, input int hold_at);
        logic [15:0] e = '0;
        for (int i = 0; i < nbits; i++) begin
            logic b = pat[15 - i];
            e = {e[14:0], b};
            send_bit(b, (i == hold_at) ? 4 : 0, padded && (i == nbits - 1), padv);
        end
        for (int i = nbits; i < 16; i++) e = {e[14:0], padv};
        sb_q.push_back('{w: e, last: padded});
        wait_wake();
        pad = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(word_out == 16'h0, "R1 word", {16'd0, word_out}, 32'd0);
        check(!wakeup, "R1 wakeup", {31'd0, wakeup}, 32'd0);
        check(!last_word, "R1 last_word", {31'd0, last_word}, 32'd0);

        // R2: strobes in idle ignored
        send_bit(1'b1, 0, 1'b0, 1'b0);
        check(word_out == 16'h0, "R2 idle strobe", {16'd0, word_out}, 32'd0);

        // R2: strobe while enable held does not shift
        in_en = 1; bit_stb = 1; data_bit = 1;
        repeat (3) @(negedge clk);
        bit_stb = 0; @(negedge clk);
        in_en = 0; @(negedge clk);
        check(word_out == 16'h0, "R2 enable held", {16'd0, word_out}, 32'd0);
        for (int i = 0; i < 15; i++) send_bit(1'b1, 0, 1'b0, 1'b0);
        check(!wakeup, "R2/R9 15 bits", {31'd0, wakeup}, 32'd0);
        sb_q.push_back('{w: 16'hFFFE, last: 1'b0});
        send_bit(1'b0, 0, 1'b0, 1'b0);
        @(negedge clk);
        rd_pulse();
        check(!wakeup && !last_word, "R5 read clears", {30'd0, wakeup, last_word}, 32'd0);

        // R3/R4 with a held strobe
        arm();
        send_word(16'hA5C3, 16, 1'b0, 1'b0, 7);
        rd_pulse();
        check(!wakeup, "R5 read", {31'd0, wakeup}, 32'd0);

        arm();
        send_word(16'h8001, 16, 1'b0, 1'b0, -1);
        rd_pulse();

        // R8: abort mid word
        arm();
        for (int i = 0; i < 5; i++) send_bit(1'b1, 0, 1'b0, 1'b0);
        rd_pulse();
        check(!wakeup, "R8 abort", {31'd0, wakeup}, 32'd0);
        arm();
        for (int i = 0; i < 15; i++) send_bit(i[0], 0, 1'b0, 1'b0);
        check(!wakeup, "R8/R9 count cleared", {31'd0, wakeup}, 32'd0);
        sb_q.push_back('{w: 16'h5554, last: 1'b0});
        send_bit(1'b0, 0, 1'b0, 1'b0);
        @(negedge clk);
        rd_pulse();

        // R6: padded partial word with ones, then R7 sequence
        arm();
        send_word(16'hC000, 4, 1'b1, 1'b1, -1);
        check(wakeup && last_word, "R6 last wake", {30'd0, wakeup, last_word}, 32'd3);
        rd_stb = 1; @(negedge clk);
        check(!wakeup && last_word, "R7 read held", {30'd0, wakeup, last_word}, 32'd1);
        repeat (3) @(negedge clk);
        check(!wakeup && last_word, "R7 read still held", {30'd0, wakeup, last_word}, 32'd1);
        rd_stb = 0; @(negedge clk);
        check(wakeup && !last_word, "R7 released", {30'd0, wakeup, last_word}, 32'd2);
        rd_pulse();
        check(!wakeup && !last_word, "R7 second read", {30'd0, wakeup, last_word}, 32'd0);

        // R6: sixteenth bit ending with pad
        arm();
        send_word(16'h1234, 16, 1'b1, 1'b0, -1);
        rd_pulse(); @(negedge clk); rd_pulse();
        check(!wakeup && !last_word, "R7 back to idle", {30'd0, wakeup, last_word}, 32'd0);

        check(sb_q.size() == 0, "R4 scoreboard drained", sb_q.size(), 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule